// File: doc/BRIEF.md
# I2C Serial EEPROM Target

This block is an I2C target that behaves like a small byte-wide serial EEPROM whose storage is an on-chip register array. It samples SCL and SDA with the system clock through two-flop synchronisers. It finds START and STOP conditions from those samples. It answers only when the select byte matches its fixed prefix and its strap pins. It pulls SDA low through an open-drain enable to acknowledge bytes and to send read data.

A host writes by sending a select byte with the direction bit clear, then a word address, then one or more data bytes. The data bytes collect in a page buffer and are copied into the array only when STOP arrives. After that copy, the block stays deaf for a programmable number of clocks. A host reads either from the current pointer, or after a dummy write that loads the address and is followed by a repeated START with the direction bit set.

One density parameter sets the array depth, the page size and how many select bits are compared with the strap pins. The select bits that are not compared become upper array address bits. A write-protect input makes the whole array read-only.

Top module: `i2c_eeprom_target`

## Requirements
- R1: During reset and immediately after it, `sda_oe` is 0 and the block is idle.
- R2: Until a START is seen, the block ignores SCL and SDA. A START is SDA falling while SCL is high. A STOP is SDA rising while SCL is high.
- R3: A select byte is acknowledged only when its bits 7..4 equal 1010 and every compared strap bit matches. Select bit 3 is compared with `addr_pins[2]`, bit 2 with `addr_pins[1]` and bit 1 with `addr_pins[0]`. Bit 0 chooses read (1) or write (0).
- R4: Density sets the comparison. At 1K and 2K all three strap bits are compared. At 4K, select bit 1 is not compared and becomes array address bit 8. At 8K, bits 2..1 become address bits 9..8. At 16K, bits 3..1 become address bits 10..8 and no strap pin is compared.
- R5: Every byte the block accepts is acknowledged by holding SDA low for the whole ninth SCL high phase. The drive starts and ends while SCL is low.
- R6: In a write, the byte after the select byte is the word address. The data bytes that follow go into the page buffer, and they enter the array only at STOP.
- R7: The page holds 8 bytes at 1K and 2K and 16 bytes at higher densities. Within a write, the offset inside the page wraps, so that a later byte overwrites an earlier one at the same offset.
- R8: After a committed write, the block ignores START and does not acknowledge any select byte for `WRITE_CYCLES` clocks. After that it answers again.
- R9: While `wp` is 1, data bytes are still acknowledged, but STOP commits nothing and does not start the busy period.
- R10: Each byte read advances the pointer by one, so a sequential read returns consecutive addresses. A read select without a word address continues from the pointer.
- R11: A master NACK after a read byte ends the transfer. The block then releases SDA and ignores clocks until the next START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level (resolved wired-AND line) |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| addr_pins | input | 3 | Strap bits compared with select bits 3..1 |
| wp | input | 1 | 1 makes the array read-only |

## Verification
A wrong internal state shows up at the ports as a missing or extra acknowledge in the ninth clock of the byte where the state went wrong. It can also show up as a wrong bit in the next read byte, which the bench reads within one byte time. A wrong page offset or block bit stays hidden until the data is read back. For that reason, every write is followed by a read over the whole page or both blocks. A busy period of the wrong length becomes visible on the first select byte sent straight after STOP, and again on one sent after the period has expired.

// File: rtl/i2c_eeprom_target.sv
module i2c_eeprom_target #(
  parameter int DENSITY_KB   = 2,
  parameter int WRITE_CYCLES = 1000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [2:0] addr_pins,
  input  logic       wp
);
  localparam int DEPTH      = DENSITY_KB * 128;
  localparam int ADDR_W     = $clog2(DEPTH);
  localparam int LOW_W      = (ADDR_W > 8) ? 8 : ADDR_W;
  localparam int BLK_W      = ADDR_W - LOW_W;
  localparam int PAGE_BYTES = (DENSITY_KB <= 2) ? 8 : 16;
  localparam int PAGE_W     = $clog2(PAGE_BYTES);
  localparam int BUSY_W     = $clog2(WRITE_CYCLES + 1);
  localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'((1 << LOW_W) - 1);

  typedef enum logic [2:0] {S_IDLE, S_RX, S_ACK, S_TX, S_MACK, S_RLOAD} state_t;
  typedef enum logic [1:0] {P_SEL, P_WORD, P_DATA} phase_t;

  logic [1:0] scl_s, sda_s;
  logic       scl_q, sda_q;
  logic       scl, sda;
  assign scl = scl_s[1];
  assign sda = sda_s[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_s <= 2'b11;
      sda_s <= 2'b11;
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_s <= {scl_s[0], scl_i};
      sda_s <= {sda_s[0], sda_i};
      scl_q <= scl;
      sda_q <= sda;
    end
  end

  logic scl_rise, scl_fall, bus_start, bus_stop;
  assign scl_rise  = scl & ~scl_q;
  assign scl_fall  = ~scl & scl_q;
  assign bus_start = scl & scl_q & sda_q & ~sda;
  assign bus_stop  = scl & scl_q & ~sda_q & sda;

  logic [7:0]            mem  [DEPTH];
  logic [7:0]            pbuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] pvld;
  state_t                st;
  phase_t                ph;
  logic [2:0]            cnt;
  logic [6:0]            rsh;
  logic [7:0]            tsh;
  logic                  rw;
  logic [ADDR_W-1:0]     ptr;
  logic [BUSY_W-1:0]     busy_cnt;
  logic                  wr_pend;
  logic                  busy;
  logic [7:0]            rx_byte, rd_byte;
  logic                  pin_ok, sel_ok;
  logic [ADDR_W-1:0]     blk_base, word_low;

  assign busy     = busy_cnt != '0;
  assign rx_byte  = {rsh, sda};
  assign rd_byte  = mem[ptr];
  assign blk_base = ADDR_W'(rx_byte[3:1]) << LOW_W;
  assign word_low = ADDR_W'(rx_byte) & LOW_MASK;

  always_comb begin
    pin_ok = 1'b1;
    for (int k = 0; k < 3; k++)
      if (k >= BLK_W && rx_byte[k+1] != addr_pins[k]) pin_ok = 1'b0;
    sel_ok = (rx_byte[7:4] == 4'b1010) && pin_ok;
  end

  logic rx_done, take_data, commit, load_tx;
  assign rx_done   = (st == S_RX) && scl_rise && (cnt == 3'd7);
  assign take_data = rx_done && (ph == P_DATA);
  assign commit    = bus_stop && wr_pend && !wp;
  assign load_tx   = scl_fall && ((st == S_ACK && sda_oe && rw) || st == S_RLOAD);

  always_ff @(posedge clk) begin
    if (take_data) pbuf[ptr[PAGE_W-1:0]] <= rx_byte;
  end

  always_ff @(posedge clk) begin
    if (commit)
      for (int i = 0; i < PAGE_BYTES; i++)
        if (pvld[i]) mem[{ptr[ADDR_W-1:PAGE_W], PAGE_W'(i)}] <= pbuf[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      ph       <= P_SEL;
      cnt      <= '0;
      rsh      <= '0;
      tsh      <= '0;
      rw       <= 1'b0;
      ptr      <= '0;
      busy_cnt <= '0;
      wr_pend  <= 1'b0;
      pvld     <= '0;
      sda_oe   <= 1'b0;
    end else begin
      if (busy) busy_cnt <= busy_cnt - 1'b1;
      if (bus_stop) begin
        st      <= S_IDLE;
        sda_oe  <= 1'b0;
        wr_pend <= 1'b0;
        pvld    <= '0;
        if (commit) busy_cnt <= BUSY_W'(WRITE_CYCLES);
      end else if (bus_start && !busy) begin
        st      <= S_RX;
        ph      <= P_SEL;
        cnt     <= '0;
        sda_oe  <= 1'b0;
        wr_pend <= 1'b0;
        pvld    <= '0;
      end else if (load_tx) begin
        tsh    <= rd_byte;
        sda_oe <= ~rd_byte[7];
        cnt    <= '0;
        st     <= S_TX;
      end else begin
        case (st)
          S_RX: if (scl_rise) begin
            rsh <= rx_byte[6:0];
            cnt <= cnt + 1'b1;
            if (cnt == 3'd7) begin
              st <= S_ACK;
              case (ph)
                P_SEL: begin
                  if (!sel_ok) st <= S_IDLE;
                  rw  <= rx_byte[0];
                  ptr <= blk_base | (ptr & LOW_MASK);
                  ph  <= rx_byte[0] ? P_DATA : P_WORD;
                end
                P_WORD: begin
                  ptr <= (ptr & ~LOW_MASK) | word_low;
                  ph  <= P_DATA;
                end
                default: begin
                  pvld[ptr[PAGE_W-1:0]] <= 1'b1;
                  wr_pend <= 1'b1;
                  ptr <= {ptr[ADDR_W-1:PAGE_W], ptr[PAGE_W-1:0] + 1'b1};
                end
              endcase
            end
          end
          S_ACK: if (scl_fall) begin
            if (!sda_oe) sda_oe <= 1'b1;
            else begin
              sda_oe <= 1'b0;
              st     <= S_RX;
            end
          end
          S_TX: if (scl_fall) begin
            if (cnt == 3'd7) begin
              sda_oe <= 1'b0;
              st     <= S_MACK;
              ptr    <= ptr + 1'b1;
            end else begin
              tsh    <= tsh << 1;
              sda_oe <= ~tsh[6];
              cnt    <= cnt + 1'b1;
            end
          end
          S_MACK: if (scl_rise) st <= sda ? S_IDLE : S_RLOAD;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_eeprom_target_chk.sv
module i2c_eeprom_target_chk (
  input logic clk,
  input logic rst_n,
  input logic sda_oe,
  input logic scl_sync,
  input logic busy,
  input logic wp
);
  // R1
  reset_release_chk: assert property (@(posedge clk) !rst_n |=> !sda_oe);

  // R5
  drive_low_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_sync);

  // R8
  busy_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sda_oe);

  // R9
  protect_no_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !$past(wp));
endmodule

bind i2c_eeprom_target i2c_eeprom_target_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe),
  .scl_sync(scl), .busy(busy), .wp(wp)
);

// File: tb/i2c_eeprom_target_test.sv
module i2c_eeprom_target_test;
  localparam int Q = 8;
  localparam int WCYC = 600;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, wp = 1'b0;
  logic [2:0] addr_pins = 3'b010;
  logic sda_oe, sda_line;
  assign sda_line = sda_m & ~sda_oe;

  always #2 clk = ~clk;

  i2c_eeprom_target #(.DENSITY_KB(4), .WRITE_CYCLES(WCYC)) uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe(sda_oe), .addr_pins(addr_pins), .wp(wp)
  );

  int nchk = 0, nfail = 0;
  bit done = 0;

  typedef struct { logic [7:0] v; string tag; } exp_t;
  exp_t sb[$];
  logic [7:0] rx_last;
  event rx_ev;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic expect_rd(input logic [7:0] v, input string tag);
    exp_t e;
    e.v = v; e.tag = tag;
    sb.push_back(e);
  endtask

  initial forever begin
    @(rx_ev);
    if (sb.size() == 0) check(0, "scoreboard-empty", rx_last, 0);
    else begin
      exp_t e;
      e = sb.pop_front();
      check(rx_last === e.v, e.tag, rx_last, e.v);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1; tick(Q); scl_m = 1; tick(Q); sda_m = 0; tick(Q); scl_m = 0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 0; tick(Q); scl_m = 1; tick(Q); sda_m = 1; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(Q); scl_m = 1; tick(2*Q); scl_m = 0; tick(Q);
    end
    sda_m = 1; tick(Q); scl_m = 1; tick(Q);
    ack = !sda_line;
    tick(Q); scl_m = 0; tick(Q);
  endtask

  task automatic recv_byte(input bit mack);
    logic [7:0] v;
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1; tick(Q); scl_m = 1; tick(Q); v[i] = sda_line; tick(Q); scl_m = 0; tick(Q);
    end
    sda_m = mack ? 1'b0 : 1'b1; tick(Q); scl_m = 1; tick(2*Q); scl_m = 0; tick(Q);
    sda_m = 1;
    rx_last = v;
    -> rx_ev;
  endtask

  task automatic send_exp(input logic [7:0] b, input bit exp, input string tag);
    bit ak;
    send_byte(b, ak);
    check(ak == exp, tag, ak, exp);
  endtask

  task automatic start_write(input logic [7:0] sel, input logic [7:0] a);
    bus_start();
    send_exp(sel, 1, "R5 select ack");
    send_exp(a, 1, "R6 word address ack");
  endtask

  task automatic read_setup(input logic [7:0] sel, input logic [7:0] a);
    start_write(sel, a);
    bus_start();
    send_exp(sel | 8'h01, 1, "R8 read select ack");
  endtask

  logic [7:0] pg [16];

  initial begin
    tick(10);
    check(sda_oe == 0, "R1 oe in reset", sda_oe, 0);
    rst_n = 1;
    tick(4);
    check(sda_oe == 0, "R1 oe after reset", sda_oe, 0);

    // R2: bytes without START are ignored
    scl_m = 0; tick(Q);
    send_exp(8'hA4, 0, "R2 no start");
    bus_stop();

    // R3: prefix and strap mismatch
    bus_start(); send_exp(8'hA0, 0, "R3 strap mismatch"); bus_stop();
    bus_start(); send_exp(8'hB4, 0, "R3 prefix mismatch"); bus_stop();

    // R6 byte write, then R8 busy probe
    start_write(8'hA4, 8'h10);
    send_exp(8'h5A, 1, "R6 data ack");
    bus_stop();
    bus_start(); send_exp(8'hA4, 0, "R8 busy nack"); bus_stop();
    tick(WCYC + 100);
    read_setup(8'hA4, 8'h10);
    expect_rd(8'h5A, "R6 byte readback");
    recv_byte(0);
    bus_stop();

    // R4: block bit from select bit 1
    start_write(8'hA6, 8'h10);
    send_exp(8'hC3, 1, "R4 block1 data ack");
    bus_stop();
    tick(WCYC + 100);
    read_setup(8'hA4, 8'h10); expect_rd(8'h5A, "R4 block0 intact"); recv_byte(0); bus_stop();
    read_setup(8'hA6, 8'h10); expect_rd(8'hC3, "R4 block1 data"); recv_byte(0); bus_stop();
    addr_pins = 3'b011;
    bus_start(); send_exp(8'hA4, 1, "R4 A0 strap not compared"); bus_stop();
    addr_pins = 3'b010;

    // R7: page write of 18 bytes starting at offset 5
    start_write(8'hA4, 8'h25);
    for (int i = 0; i < 18; i++) send_exp(8'(8'h80 + i), 1, "R7 page data ack");
    bus_stop();
    tick(WCYC + 100);
    for (int o = 0; o < 16; o++)
      pg[o] = (o < 5) ? 8'(8'h8B + o) : (o == 5) ? 8'h90 : (o == 6) ? 8'h91 : 8'(8'h80 + o - 5);
    read_setup(8'hA4, 8'h20);
    for (int o = 0; o < 16; o++) begin
      expect_rd(pg[o], "R7 R10 page wrap sequential");
      recv_byte(o != 15);
    end
    bus_stop();

    // R10: current-address read continues from pointer
    read_setup(8'hA4, 8'h20);
    expect_rd(pg[0], "R10 seq byte0"); recv_byte(1);
    expect_rd(pg[1], "R10 seq byte1"); recv_byte(0);
    bus_stop();
    bus_start();
    send_exp(8'hA5, 1, "R10 current read select");
    expect_rd(pg[2], "R10 current address");
    recv_byte(0);
    // R11: after NACK the block stays off the bus
    check(sda_oe == 0, "R11 released after nack", sda_oe, 0);
    expect_rd(8'hFF, "R11 idle after nack");
    recv_byte(0);
    bus_stop();

    // R9: write protect
    wp = 1;
    start_write(8'hA4, 8'h10);
    send_exp(8'h11, 1, "R9 protected data ack");
    bus_stop();
    bus_start();
    send_exp(8'hA4, 1, "R9 no busy after protected write");
    send_exp(8'h10, 1, "R9 address ack");
    bus_start();
    send_exp(8'hA5, 1, "R9 read select");
    expect_rd(8'h5A, "R9 array unchanged");
    recv_byte(0);
    bus_stop();
    wp = 0;

    tick(20);
    check(sb.size() == 0, "scoreboard drained", sb.size(), 0);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      check(0, "watchdog", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end
endmodule